// File: doc/BRIEF.md
# Latched Event Interrupt Controller

This block gathers event and fault flags from a small power-management device and drives one active-low interrupt line toward a host microcontroller. Each source has its own sticky status bit. A one-cycle pulse on the source sets the bit, and the bit stays set until the host reads it. The host reaches the block through a simple register read/write port, which stands in for the serial link in front of it. The sources are laid out in groups of `GRP_W` bits, and each group has its own status address.

Each source is one of two types. The `WAKE_SRC` parameter marks the wake-up sources, and every other source is a run-time fault. A latched bit can pull the interrupt low only when three conditions hold:
- its mask bit is 1;
- the present operating mode qualifies its type;
- the bit is still pending.

The interrupt is registered. It goes back high once the host has read every group that holds a qualified, enabled pending bit.

Top module: `event_irq_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high) clears every status bit, loads every mask bit with `MASK_RST` (all ones by default), clears `rdata_o` and drives `irq_n_o` high.
- R2: A 1 on `evt_i[s]` at a clock edge sets status bit `s`. The bit stays set until a read of its group, and that read returns it in bit position `s mod GRP_W`.
- R3: A read (`rd_i`=1) of status address `g`, in the range 0 to `N_SRC/GRP_W-1`, registers the group's bits into `rdata_o` on that edge. The same edge clears every bit of that group and no bit of any other group.
- R4: When a source pulses on the same edge as a read of its group, the read returns the old value and the bit remains set afterwards.
- R5: The mask bits are readable and writable at address `N_SRC/GRP_W + g`, and a mask bit of 1 enables its source. A masked source still latches and reads back, but it does not drive the interrupt.
- R6: A fault source, meaning one whose bit in `WAKE_SRC` is 0, can drive the interrupt only in mode 0 (Normal) or mode 1 (Normal Request).
- R7: A wake source, meaning one whose bit in `WAKE_SRC` is 1, can drive the interrupt in mode 0, mode 1 or mode 2 (Stop).
- R8: In mode 3 (Sleep), no bit drives the interrupt. Bits still latch, and they assert the interrupt once the mode qualifies them.
- R9: `irq_n_o` is registered. It is low exactly one clock after a qualified, enabled pending bit exists, and high one clock after none remains.
- R10: A write to a status address changes nothing, and a read of a mask address clears no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_i | input | N_SRC | Event pulses, one per source |
| mode_i | input | 2 | Operating mode: 0 Normal, 1 Normal Request, 2 Stop, 3 Sleep |
| rd_i | input | 1 | Register read strobe |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address: status groups first, then mask groups |
| wdata_i | input | GRP_W | Write data |
| rdata_o | output | GRP_W | Registered read data, updated on each read and held otherwise |
| irq_n_o | output | 1 | Interrupt request, active low |

## Verification
The assertions take three things for granted about the inputs:
- reset is high from time zero until the first sampled edge;
- every input carries a known value at each rising edge;
- `mode_i` is a defined two-bit code.

The assertions do not require event inputs to be single-cycle pulses, and they do not assume that reads and writes exclude each other. The stimulus changes inputs only on falling edges, and it uses only addresses inside the four-entry map of the default configuration. It holds the mode steady for at least one cycle before each event, so every interrupt level the bench expects follows from a settled mode.

// File: rtl/lei_pkg.sv
package lei_pkg;

   typedef enum logic [1:0] {
      MODE_RUN     = 2'd0,
      MODE_RUN_REQ = 2'd1,
      MODE_STOP    = 2'd2,
      MODE_SLEEP   = 2'd3
   } pwr_mode_e;

   // run-time faults are reported only while the device is running
   function automatic logic fault_qualified(pwr_mode_e m);
      return (m == MODE_RUN) || (m == MODE_RUN_REQ);
   endfunction

   // wake events are also reported when they arrive during Stop
   function automatic logic wake_qualified(pwr_mode_e m);
      return (m != MODE_SLEEP);
   endfunction

endpackage

// File: rtl/lei_status_group.sv
module lei_status_group #(
   parameter int GRP_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [GRP_W-1:0] evt,
   input  logic             clr,
   output logic [GRP_W-1:0] bits
);

   // a read clears all bits it returned; events on the same edge survive
   always_ff @(posedge clk) begin
      if (rst)
         bits <= '0;
      else if (clr)
         bits <= evt;
      else
         bits <= bits | evt;
   end

   for (genvar i = 0; i < GRP_W; i++) begin : g_chk
      p_sticky_set_r2: assert property (@(posedge clk) disable iff (rst)
         evt[i] |=> bits[i]);
      p_sticky_hold_r2: assert property (@(posedge clk) disable iff (rst)
         (bits[i] && !clr) |=> bits[i]);
      p_clear_on_read_r3: assert property (@(posedge clk) disable iff (rst)
         (clr && !evt[i]) |=> !bits[i]);
      p_set_wins_r4: assert property (@(posedge clk) disable iff (rst)
         (clr && evt[i]) |=> bits[i]);
   end

endmodule

// File: rtl/lei_qualify.sv
module lei_qualify
   import lei_pkg::*;
#(
   parameter int               N_SRC    = 8,
   parameter logic [N_SRC-1:0] WAKE_SRC = '0
) (
   input  logic [N_SRC-1:0] status,
   input  logic [N_SRC-1:0] mask,
   input  pwr_mode_e        mode,
   output logic             pending
);

   logic [N_SRC-1:0] gate;

   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      if (WAKE_SRC[i]) begin : g_wake
         assign gate[i] = wake_qualified(mode);
      end else begin : g_fault
         assign gate[i] = fault_qualified(mode);
      end
   end

   assign pending = |(status & mask & gate);

endmodule

// File: rtl/lei_regs.sv
module lei_regs #(
   parameter int               N_SRC    = 8,
   parameter int               GRP_W    = 4,
   parameter logic [N_SRC-1:0] MASK_RST = '1,
   parameter int               ADDR_W   = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rd,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [GRP_W-1:0]  wdata,
   input  logic [N_SRC-1:0]  status,
   output logic [N_SRC-1:0]  mask,
   output logic [GRP_W-1:0]  rdata,
   output logic [N_SRC/GRP_W-1:0] clr_grp
);

   localparam int NGRP = N_SRC / GRP_W;

   logic [GRP_W-1:0] rd_val;

   always_comb begin
      rd_val  = '0;
      clr_grp = '0;
      for (int g = 0; g < NGRP; g++) begin
         if (addr == ADDR_W'(g)) begin
            rd_val     = rd_val | status[g*GRP_W +: GRP_W];
            clr_grp[g] = rd;
         end
         if (addr == ADDR_W'(NGRP + g))
            rd_val = rd_val | mask[g*GRP_W +: GRP_W];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         mask  <= MASK_RST;
         rdata <= '0;
      end else begin
         if (rd)
            rdata <= rd_val;
         for (int g = 0; g < NGRP; g++)
            if (wr && addr == ADDR_W'(NGRP + g))
               mask[g*GRP_W +: GRP_W] <= wdata;
      end
   end

   p_mask_hold_r5: assert property (@(posedge clk) disable iff (rst)
      !wr |=> $stable(mask));
   p_mask_write_r5: assert property (@(posedge clk) disable iff (rst)
      (wr && addr == ADDR_W'(NGRP)) |=> (mask[GRP_W-1:0] == $past(wdata)));
   p_read_hold_r3: assert property (@(posedge clk) disable iff (rst)
      !rd |=> $stable(rdata));

endmodule

// File: rtl/event_irq_ctrl.sv
module event_irq_ctrl
   import lei_pkg::*;
#(
   parameter int               N_SRC    = 8,
   parameter int               GRP_W    = 4,
   parameter logic [N_SRC-1:0] WAKE_SRC = 8'hC0,
   parameter logic [N_SRC-1:0] MASK_RST = '1,
   localparam int              NGRP     = N_SRC / GRP_W,
   localparam int              ADDR_W   = $clog2(2 * NGRP)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [N_SRC-1:0]  evt_i,
   input  logic [1:0]        mode_i,
   input  logic              rd_i,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [GRP_W-1:0]  wdata_i,
   output logic [GRP_W-1:0]  rdata_o,
   output logic              irq_n_o
);

   if (GRP_W < 1 || N_SRC < GRP_W) begin : g_bad_width
      $error("event_irq_ctrl: GRP_W must be at least 1 and at most N_SRC");
   end
   if (N_SRC % GRP_W != 0) begin : g_bad_split
      $error("event_irq_ctrl: N_SRC must be a multiple of GRP_W");
   end

   pwr_mode_e        mode;
   logic [N_SRC-1:0] status;
   logic [N_SRC-1:0] mask;
   logic [NGRP-1:0]  clr_grp;
   logic             pending;

   assign mode = pwr_mode_e'(mode_i);

   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      lei_status_group #(.GRP_W(GRP_W)) i_grp (
         .clk  (clk),
         .rst  (rst),
         .evt  (evt_i[g*GRP_W +: GRP_W]),
         .clr  (clr_grp[g]),
         .bits (status[g*GRP_W +: GRP_W])
      );
   end

   lei_regs #(
      .N_SRC(N_SRC), .GRP_W(GRP_W), .MASK_RST(MASK_RST), .ADDR_W(ADDR_W)
   ) i_regs (
      .clk     (clk),
      .rst     (rst),
      .rd      (rd_i),
      .wr      (wr_i),
      .addr    (addr_i),
      .wdata   (wdata_i),
      .status  (status),
      .mask    (mask),
      .rdata   (rdata_o),
      .clr_grp (clr_grp)
   );

   lei_qualify #(.N_SRC(N_SRC), .WAKE_SRC(WAKE_SRC)) i_qual (
      .status  (status),
      .mask    (mask),
      .mode    (mode),
      .pending (pending)
   );

   always_ff @(posedge clk) begin
      if (rst)
         irq_n_o <= 1'b1;
      else
         irq_n_o <= !pending;
   end

   p_reset_state_r1: assert property (@(posedge clk)
      rst |=> (irq_n_o && rdata_o == '0 && status == '0));
   p_irq_fall_r9: assert property (@(posedge clk) disable iff (rst)
      pending |=> !irq_n_o);
   p_irq_rise_r9: assert property (@(posedge clk) disable iff (rst)
      !pending |=> irq_n_o);
   p_sleep_quiet_r8: assert property (@(posedge clk) disable iff (rst)
      (mode == MODE_SLEEP) |=> irq_n_o);
   p_masked_quiet_r5: assert property (@(posedge clk) disable iff (rst)
      ((status & mask) == '0) |=> irq_n_o);

endmodule

// File: tb/test_event_irq_ctrl.sv
module test_event_irq_ctrl;

   localparam int          N    = 8;
   localparam int          GW   = 4;
   localparam int          NG   = N / GW;
   localparam int          AW   = 2;
   localparam logic [N-1:0] WAKE = 8'hC0;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [N-1:0]  evt = '0;
   logic [1:0]    mode = 2'd0;
   logic          rd = 1'b0;
   logic          wr = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [GW-1:0] wdata = '0;
   logic [GW-1:0] rdata;
   logic          irq_n;

   int checks = 0;
   int fails  = 0;
   logic [GW-1:0] v;

   always #10 clk = ~clk;

   event_irq_ctrl #(.N_SRC(N), .GRP_W(GW), .WAKE_SRC(WAKE)) i_event_irq_ctrl (
      .clk(clk), .rst(rst), .evt_i(evt), .mode_i(mode), .rd_i(rd), .wr_i(wr),
      .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_n_o(irq_n)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic do_read(input int a, output logic [GW-1:0] val);
      rd = 1'b1; addr = AW'(a);
      cyc();
      rd = 1'b0;
      val = rdata;
   endtask

   task automatic do_write(input int a, input logic [GW-1:0] d);
      wr = 1'b1; addr = AW'(a); wdata = d;
      cyc();
      wr = 1'b0;
   endtask

   // expected interrupt level for one pending source
   function automatic logic exp_irq_n(input int s, input int m, input bit masked);
      bit ok;
      ok = WAKE[s] ? (m != 3) : (m < 2);
      return !(ok && !masked);
   endfunction

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) cyc();
      chk("R1 irq high in reset", 32'(irq_n), 32'd1);
      rst = 1'b0;
      cyc();
      chk("R1 rdata after reset", 32'(rdata), 32'd0);
      chk("R1 irq after reset", 32'(irq_n), 32'd1);
      do_read(NG, v);
      chk("R1 mask reset value", 32'(v), 32'hF);
      do_read(0, v);
      chk("R1 status reset value", 32'(v), 32'd0);

      // sweep: every mode x every source x masked/unmasked
      for (int m = 0; m < 4; m++) begin
         for (int s = 0; s < N; s++) begin
            for (int k = 0; k < 2; k++) begin
               logic exp_n;
               mode = 2'(m);
               if (k == 1) do_write(NG + s / GW, ~(GW'(1) << (s % GW)));
               cyc();
               exp_n = exp_irq_n(s, m, k == 1);
               evt[s] = 1'b1;
               cyc();
               evt = '0;
               chk("R9 irq not early", 32'(irq_n), 32'd1);
               cyc();
               if (WAKE[s])
                  chk("R7 R8 R5 wake irq level", 32'(irq_n), 32'(exp_n));
               else
                  chk("R6 R8 R5 fault irq level", 32'(irq_n), 32'(exp_n));
               do_read(s / GW, v);
               chk("R2 latched bit", 32'(v), 32'(GW'(1) << (s % GW)));
               cyc();
               chk("R9 irq released after read", 32'(irq_n), 32'd1);
               do_read(s / GW, v);
               chk("R3 cleared by read", 32'(v), 32'd0);
               if (k == 1) do_write(NG + s / GW, 4'hF);
            end
         end
      end

      // R3: a read clears only its own group
      mode = 2'd0;
      evt = 8'h22;
      cyc();
      evt = '0;
      cyc();
      do_read(0, v);
      chk("R3 group0 value", 32'(v), 32'h2);
      cyc();
      chk("R3 other group still pending", 32'(irq_n), 32'd0);
      do_read(1, v);
      chk("R3 group1 value", 32'(v), 32'h2);
      cyc();
      chk("R3 irq high after both reads", 32'(irq_n), 32'd1);

      // R4: set on the same edge as the clearing read
      evt = 8'h04;
      cyc();
      evt = 8'h04; rd = 1'b1; addr = 2'd0;
      cyc();
      evt = '0; rd = 1'b0;
      chk("R4 read returns old value", 32'(rdata), 32'h4);
      do_read(0, v);
      chk("R4 bit survives clear", 32'(v), 32'h4);
      do_read(0, v);
      chk("R4 bit cleared by later read", 32'(v), 32'h0);

      // R10: status write ignored, mask read does not clear
      do_write(0, 4'hF);
      do_read(0, v);
      chk("R10 status write ignored", 32'(v), 32'h0);
      evt = 8'h01;
      cyc();
      evt = '0;
      do_read(NG, v);
      chk("R10 mask read value", 32'(v), 32'hF);
      do_read(0, v);
      chk("R10 mask read left status", 32'(v), 32'h1);
      cyc();
      chk("R10 irq high after clear", 32'(irq_n), 32'd1);

      // R8: fault latched in Sleep asserts once mode qualifies
      mode = 2'd3;
      cyc();
      evt = 8'h01;
      cyc();
      evt = '0;
      cyc();
      chk("R8 no irq in sleep", 32'(irq_n), 32'd1);
      mode = 2'd0;
      cyc();
      cyc();
      chk("R8 irq once mode qualifies", 32'(irq_n), 32'd0);
      do_read(0, v);
      chk("R8 bit kept across sleep", 32'(v), 32'h1);

      // R5: mask write and read back
      do_write(NG + 1, 4'h5);
      do_read(NG + 1, v);
      chk("R5 mask readback", 32'(v), 32'h5);
      do_write(NG + 1, 4'hF);

      finish_run();
   end

endmodule